// File: doc/BRIEF.md
# Panel Power Sequencer

The block brings a display panel's supply rails and timing-generator state up or down by issuing a fixed, ordered script of short register writes. Each write is a frame with a 3-bit register address and a 5-bit value, handed to a serial framer over a valid/ready handshake. Between certain writes the script holds for a set number of milliseconds. In the middle of each script it hands an 8-bit bias value to an external DAC write sequencer and waits for that sequencer to finish.

A script starts only when the requested power level differs from the level the block last reached. The power-up script uses the resolution mode, the phase-adjust value and the bias value, all captured when the script starts. The power-down script opens with a hold of two 60 Hz frame times. If the request changes while a script runs, the script still completes. The block then compares the request level again and, if it still differs, runs the opposite script.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset `busy_o` and `pwr_on_o` are 0, and no frame or DAC start is issued while the request stays low.
- R2: A script starts only when `pwr_req_i` differs from `pwr_on_o`. A request equal to the current level issues no frame and no DAC start.
- R3: A frame (`frm_addr_o` 3 bits, `frm_data_o` 5 bits) stays valid and unchanged until `frm_ready_i` accepts it. The next step starts only after that acceptance.
- R4: In QVGA mode (`vga_mode_i`=0), power-up issues these frames as address:data pairs, in this order:
  - 6:1F, 3:03, 4:00, 4:04, 3:07, 6:09
  - then the DAC step
  - then 3:17, 4:06, 6:01, 3:1F, 4:07, 6:00, 1:13, 7:00, 0:01
- R5: In VGA mode (`vga_mode_i`=1), the phase frame (address 1) carries 0x01 OR (phase << 1) when `phase_vld_i` is high, and 0x01 when it is low. The final resolution frame (address 0) carries 0x00.
- R6: During power-up, holds of at least 3 ms, 2 ms and 1 ms follow the acceptance of frames 4:04, 4:06 and 7:00 respectively. One millisecond is `TICKS_PER_MS` clock cycles.
- R7: The DAC step raises `dac_start_o` for exactly one cycle, with no frame valid in that cycle, and the script waits for `dac_done_i`. On power-up the step sends base 0x04 and value `bias_i` if `bias_vld_i` is high, otherwise 125. On power-down it sends base 0x14 and value 0.
- R8: Power-down first holds for at least 34 ms. It then issues 4:06, 6:08, 3:14, then the DAC step, then 4:04, 3:04, 6:1E, 3:00, 4:00.
- R9: `busy_o` is high while a script runs. `pwr_on_o` changes only in the cycle a script ends, and takes that script's direction.
- R10: A request change during a script is acted on only after the script ends, against the request level present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 1 | Requested power level |
| vga_mode_i | input | 1 | 1 = VGA, 0 = QVGA |
| phase_i | input | 4 | Phase-adjust value |
| phase_vld_i | input | 1 | Phase value is valid |
| bias_i | input | 8 | Common bias value |
| bias_vld_i | input | 1 | Bias value is valid |
| frm_valid_o | output | 1 | Frame request valid |
| frm_ready_i | input | 1 | Framer accepts frame |
| frm_addr_o | output | 3 | Frame register address |
| frm_data_o | output | 5 | Frame register data |
| dac_start_o | output | 1 | Start pulse for DAC write sequencer |
| dac_base_o | output | 5 | Base value for the DAC write |
| dac_value_o | output | 8 | Value for the DAC write |
| dac_done_i | input | 1 | DAC write finished |
| busy_o | output | 1 | Script running |
| pwr_on_o | output | 1 | Current power level |

## Verification
The assertions check, on every cycle:
- that a stalled frame holds steady;
- that the block is silent when idle;
- that a script starts only on a level mismatch;
- that the DAC start is a lone pulse exclusive of frames;
- that the power level moves only at a script's end.

Only the bench scenarios can show the exact order and values of each script in both modes, the bias fallback, and the hold lengths. The same is true of how a request that changes mid-script is serviced after the script completes.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {K_WRITE, K_DELAY, K_DAC, K_END} step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic [2:0]  addr;
    logic [4:0]  data;
    logic [5:0]  ms;
  } step_t;

  localparam logic [2:0] A_RES  = 3'd0;
  localparam logic [2:0] A_PHS  = 3'd1;
  localparam logic [2:0] A_PWR0 = 3'd3;
  localparam logic [2:0] A_PWR1 = 3'd4;
  localparam logic [2:0] A_IFC  = 3'd6;
  localparam logic [2:0] A_POL  = 3'd7;
endpackage

// File: rtl/pps_script.sv
module pps_script
  import pps_pkg::*;
#(
  parameter int PC_W       = 5,
  parameter int QVGA_PHASE = 9
) (
  input  logic            dir_up_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            vga_i,
  input  logic            phase_vld_i,
  input  logic [3:0]      phase_i,
  output step_t           step_o
);
  function automatic step_t wr(input logic [2:0] a, input logic [4:0] d);
    wr = '{kind: K_WRITE, addr: a, data: d, ms: 6'd0};
  endfunction
  function automatic step_t dly(input logic [5:0] m);
    dly = '{kind: K_DELAY, addr: 3'd0, data: 5'd0, ms: m};
  endfunction
  function automatic step_t dac(input logic [4:0] base);
    dac = '{kind: K_DAC, addr: 3'd0, data: base, ms: 6'd0};
  endfunction

  logic [4:0] phase_val;
  logic [4:0] res_val;

  always_comb begin
    if (!vga_i)          phase_val = {4'(QVGA_PHASE), 1'b1};
    else if (phase_vld_i) phase_val = {phase_i, 1'b1};
    else                 phase_val = 5'h01;
    res_val = vga_i ? 5'h00 : 5'h01;
  end

  always_comb begin
    step_o = '{kind: K_END, addr: 3'd0, data: 5'd0, ms: 6'd0};
    if (dir_up_i) begin
      case (pc_i)
        5'd0:  step_o = wr(A_IFC,  5'h1F);
        5'd1:  step_o = wr(A_PWR0, 5'h03);
        5'd2:  step_o = wr(A_PWR1, 5'h00);
        5'd3:  step_o = wr(A_PWR1, 5'h04);
        5'd4:  step_o = dly(6'd3);
        5'd5:  step_o = wr(A_PWR0, 5'h07);
        5'd6:  step_o = wr(A_IFC,  5'h09);
        5'd7:  step_o = dac(5'h04);
        5'd8:  step_o = wr(A_PWR0, 5'h17);
        5'd9:  step_o = wr(A_PWR1, 5'h06);
        5'd10: step_o = dly(6'd2);
        5'd11: step_o = wr(A_IFC,  5'h01);
        5'd12: step_o = wr(A_PWR0, 5'h1F);
        5'd13: step_o = wr(A_PWR1, 5'h07);
        5'd14: step_o = wr(A_IFC,  5'h00);
        5'd15: step_o = wr(A_PHS,  phase_val);
        5'd16: step_o = wr(A_POL,  5'h00);
        5'd17: step_o = dly(6'd1);
        5'd18: step_o = wr(A_RES,  res_val);
        default: ;
      endcase
    end else begin
      case (pc_i)
        5'd0:  step_o = dly(6'd34);
        5'd1:  step_o = wr(A_PWR1, 5'h06);
        5'd2:  step_o = wr(A_IFC,  5'h08);
        5'd3:  step_o = wr(A_PWR0, 5'h14);
        5'd4:  step_o = dac(5'h14);
        5'd5:  step_o = wr(A_PWR1, 5'h04);
        5'd6:  step_o = wr(A_PWR0, 5'h04);
        5'd7:  step_o = wr(A_IFC,  5'h1E);
        5'd8:  step_o = wr(A_PWR0, 5'h00);
        5'd9:  step_o = wr(A_PWR1, 5'h00);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
  parameter int TICKS_PER_MS = 50000,
  parameter int MS_W         = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            done_o
);
  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICKS_PER_MS - 1);

  logic             run_q;
  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;

  assign done_o = run_q && (pre_q == '0) && (ms_q == MS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pre_q <= '0;
      ms_q  <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      pre_q <= PRE_TOP;
      ms_q  <= ms_i;
    end else if (run_q) begin
      if (pre_q == '0) begin
        pre_q <= PRE_TOP;
        ms_q  <= ms_q - 1'b1;
        if (ms_q == MS_W'(1)) run_q <= 1'b0;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int TICKS_PER_MS = 50000,
  parameter int DEF_BIAS     = 125,
  parameter int QVGA_PHASE   = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_req_i,
  input  logic       vga_mode_i,
  input  logic [3:0] phase_i,
  input  logic       phase_vld_i,
  input  logic [7:0] bias_i,
  input  logic       bias_vld_i,
  output logic       frm_valid_o,
  input  logic       frm_ready_i,
  output logic [2:0] frm_addr_o,
  output logic [4:0] frm_data_o,
  output logic       dac_start_o,
  output logic [4:0] dac_base_o,
  output logic [7:0] dac_value_o,
  input  logic       dac_done_i,
  output logic       busy_o,
  output logic       pwr_on_o
);
  localparam int PC_W = 5;
  localparam int MS_W = 6;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_DAC} state_e;

  state_e          state_q;
  logic [PC_W-1:0] pc_q;
  logic            dir_q, on_q;
  logic            vga_q, phv_q;
  logic [3:0]      ph_q;
  logic [7:0]      bias_q;
  step_t           step;
  logic            tmr_start, tmr_done;

  pps_script #(.PC_W(PC_W), .QVGA_PHASE(QVGA_PHASE)) u_script (
    .dir_up_i   (dir_q),
    .pc_i       (pc_q),
    .vga_i      (vga_q),
    .phase_vld_i(phv_q),
    .phase_i    (ph_q),
    .step_o     (step)
  );

  pps_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .ms_i   (step.ms),
    .done_o (tmr_done)
  );

  assign frm_valid_o = (state_q == S_RUN) && (step.kind == K_WRITE);
  assign frm_addr_o  = step.addr;
  assign frm_data_o  = step.data;
  assign dac_start_o = (state_q == S_RUN) && (step.kind == K_DAC);
  assign dac_base_o  = step.data;
  assign dac_value_o = bias_q;
  assign tmr_start   = (state_q == S_RUN) && (step.kind == K_DELAY);
  assign busy_o      = (state_q != S_IDLE);
  assign pwr_on_o    = on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      dir_q   <= 1'b0;
      on_q    <= 1'b0;
      vga_q   <= 1'b0;
      phv_q   <= 1'b0;
      ph_q    <= '0;
      bias_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (pwr_req_i != on_q) begin
          // capture script inputs once per run
          dir_q   <= pwr_req_i;
          pc_q    <= '0;
          vga_q   <= vga_mode_i;
          phv_q   <= phase_vld_i;
          ph_q    <= phase_i;
          bias_q  <= !pwr_req_i ? 8'd0 : (bias_vld_i ? bias_i : 8'(DEF_BIAS));
          state_q <= S_RUN;
        end
        S_RUN: case (step.kind)
          K_WRITE: if (frm_ready_i) pc_q <= pc_q + 1'b1;
          K_DELAY: state_q <= S_WAIT;
          K_DAC:   state_q <= S_DAC;
          default: begin
            on_q    <= dir_q;
            state_q <= S_IDLE;
          end
        endcase
        S_WAIT: if (tmr_done) begin
          pc_q    <= pc_q + 1'b1;
          state_q <= S_RUN;
        end
        default: if (dac_done_i) begin
          pc_q    <= pc_q + 1'b1;
          state_q <= S_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_req_i,
  input logic       frm_valid_o,
  input logic       frm_ready_i,
  input logic [2:0] frm_addr_o,
  input logic [4:0] frm_data_o,
  input logic       dac_start_o,
  input logic       busy_o,
  input logic       pwr_on_o
);
  p_hold_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && !frm_ready_i |=> frm_valid_o && $stable(frm_addr_o) && $stable(frm_data_o));

  p_addr_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o |-> (frm_addr_o != 3'd2) && (frm_addr_o != 3'd5));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !frm_valid_o && !dac_start_o);

  p_start_mismatch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(pwr_req_i) != $past(pwr_on_o));

  p_dac_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_start_o |=> !dac_start_o);

  p_dac_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_start_o |-> !frm_valid_o && busy_o);

  p_state_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pwr_on_o) |-> $past(busy_o) && !busy_o);
endmodule

bind panel_pwr_seq pps_checker u_pps_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_req_i  (pwr_req_i),
  .frm_valid_o(frm_valid_o),
  .frm_ready_i(frm_ready_i),
  .frm_addr_o (frm_addr_o),
  .frm_data_o (frm_data_o),
  .dac_start_o(dac_start_o),
  .busy_o     (busy_o),
  .pwr_on_o   (pwr_on_o)
);

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb_top;
  localparam int TPM = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwr_req_i = 1'b0;
  logic       vga_mode_i = 1'b0;
  logic [3:0] phase_i = '0;
  logic       phase_vld_i = 1'b0;
  logic [7:0] bias_i = '0;
  logic       bias_vld_i = 1'b0;
  logic       frm_valid_o;
  logic       frm_ready_i = 1'b1;
  logic [2:0] frm_addr_o;
  logic [4:0] frm_data_o;
  logic       dac_start_o;
  logic [4:0] dac_base_o;
  logic [7:0] dac_value_o;
  logic       dac_done_i = 1'b0;
  logic       busy_o;
  logic       pwr_on_o;

  panel_pwr_seq #(.TICKS_PER_MS(TPM)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {
    bit         is_dac;
    logic [2:0] addr;
    logic [7:0] data;
    int         gms;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   last_ref = 0;
  bit   stall_en = 1'b0;
  bit   done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic pf(input logic [2:0] a, input logic [7:0] d, input int g, input string t);
    exp_t e;
    e.is_dac = 1'b0; e.addr = a; e.data = d; e.gms = g; e.tag = t;
    q.push_back(e);
  endtask

  task automatic pd(input logic [7:0] base, input logic [7:0] v, input string t);
    exp_t e;
    e.is_dac = 1'b1; e.addr = base[2:0]; e.data = {3'b0, base[4:0]}; e.gms = 0; e.tag = t;
    q.push_back(e);
    e.data = v; e.tag = {t, " value"}; e.is_dac = 1'b1; e.gms = -1;
    q.push_back(e);
  endtask

  // driver: expected power-up items (R4, R5, R6, R7)
  task automatic push_up(input bit vga, input bit pv, input logic [3:0] p, input bit bv, input logic [7:0] b);
    logic [4:0] ph;
    ph = !vga ? 5'h13 : (pv ? {p, 1'b1} : 5'h01);
    pf(3'd6, 8'h1F, 0, "R4"); pf(3'd3, 8'h03, 0, "R4"); pf(3'd4, 8'h00, 0, "R4");
    pf(3'd4, 8'h04, 0, "R4"); pf(3'd3, 8'h07, 3, "R6"); pf(3'd6, 8'h09, 0, "R4");
    pd(8'h04, bv ? b : 8'd125, "R7");
    pf(3'd3, 8'h17, 0, "R4"); pf(3'd4, 8'h06, 0, "R4"); pf(3'd6, 8'h01, 2, "R6");
    pf(3'd3, 8'h1F, 0, "R4"); pf(3'd4, 8'h07, 0, "R4"); pf(3'd6, 8'h00, 0, "R4");
    pf(3'd1, {3'b0, ph}, 0, "R5"); pf(3'd7, 8'h00, 0, "R4");
    pf(3'd0, vga ? 8'h00 : 8'h01, 1, "R5");
  endtask

  // driver: expected power-down items (R8, R7)
  task automatic push_down();
    pf(3'd4, 8'h06, 34, "R8"); pf(3'd6, 8'h08, 0, "R8"); pf(3'd3, 8'h14, 0, "R8");
    pd(8'h14, 8'h00, "R7");
    pf(3'd4, 8'h04, 0, "R8"); pf(3'd3, 8'h04, 0, "R8"); pf(3'd6, 8'h1E, 0, "R8");
    pf(3'd3, 8'h00, 0, "R8"); pf(3'd4, 8'h00, 0, "R8");
  endtask

  task automatic wait_idle(input bit exp_on, input string tag);
    int n;
    n = 0;
    while ((q.size() != 0 || busy_o) && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
    repeat (4) @(negedge clk_i);
    chk(q.size() == 0 && !busy_o, {tag, " script done"}, q.size(), 0);
    chk(pwr_on_o == exp_on, {tag, " power state"}, pwr_on_o, exp_on);
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk_i);
    chk(!busy_o, "R2 no script on equal request", busy_o, 0);
  endtask

  // ready pattern and cycle count
  initial begin
    forever begin
      @(negedge clk_i);
      frm_ready_i = !(stall_en && (cyc % 3 == 0));
    end
  end

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor / scoreboard
  initial begin
    bit         pv = 1'b0, pr = 1'b1;
    logic [2:0] pa = '0;
    logic [4:0] pdt = '0;
    int         dcnt = 0;
    exp_t       it;
    forever begin
      @(negedge clk_i);
      if (dac_done_i) dac_done_i = 1'b0;
      if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0) dac_done_i = 1'b1;
      end
      if (rst_ni && pv && !pr)  // R3 hold while stalled
        chk(frm_valid_o && frm_addr_o == pa && frm_data_o == pdt, "R3 frame held",
            {frm_valid_o, frm_addr_o, frm_data_o}, {1'b1, pa, pdt});
      if (rst_ni && frm_valid_o && frm_ready_i) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", {frm_addr_o, frm_data_o}, 0);
        end else begin
          it = q.pop_front();
          chk(!it.is_dac && frm_addr_o == it.addr && frm_data_o == it.data[4:0],
              {it.tag, " frame"}, {frm_addr_o, frm_data_o}, {it.addr, it.data[4:0]});
          if (it.gms > 0) begin
            chk(cyc - last_ref >= it.gms * TPM && cyc - last_ref <= it.gms * TPM + 10,
                {it.tag, " hold length"}, cyc - last_ref, it.gms * TPM);
          end
        end
        last_ref = cyc;
      end
      if (rst_ni && dac_start_o) begin
        if (q.size() < 2) begin
          chk(1'b0, "R7 unexpected DAC start", dac_base_o, 0);
        end else begin
          it = q.pop_front();
          chk(it.is_dac && dac_base_o == it.data[4:0], "R7 DAC base", dac_base_o, it.data);
          it = q.pop_front();
          chk(dac_value_o == it.data, "R7 DAC value", dac_value_o, it.data);
        end
        dcnt = 4;
      end
      pv  = frm_valid_o;
      pr  = frm_ready_i;
      pa  = frm_addr_o;
      pdt = frm_data_o;
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!busy_o, "R1 busy at reset", busy_o, 0);
    chk(!pwr_on_o, "R1 power at reset", pwr_on_o, 0);
    chk(!frm_valid_o && !dac_start_o, "R1 quiet at reset", frm_valid_o, 0);
    rst_ni = 1'b1;
    quiet(50);

    // QVGA power-up with stalls, bias invalid -> 125 (R4, R3, R7)
    stall_en = 1'b1;
    push_up(1'b0, 1'b0, 4'h0, 1'b0, 8'h00);
    pwr_req_i = 1'b1;
    @(negedge clk_i);
    chk(busy_o, "R9 busy after request", busy_o, 1);
    chk(!pwr_on_o, "R9 power unchanged mid-script", pwr_on_o, 0);
    wait_idle(1'b1, "R4");
    stall_en = 1'b0;
    quiet(100);  // R2 repeated request

    // power-down (R8)
    push_down();
    last_ref = cyc;
    pwr_req_i = 1'b0;
    wait_idle(1'b0, "R8");
    quiet(60);

    // VGA with phase and bias valid (R5, R7)
    vga_mode_i = 1'b1; phase_vld_i = 1'b1; phase_i = 4'h5;
    bias_vld_i = 1'b1; bias_i = 8'h33;
    push_up(1'b1, 1'b1, 4'h5, 1'b1, 8'h33);
    pwr_req_i = 1'b1;
    wait_idle(1'b1, "R5");
    push_down();
    last_ref = cyc;
    pwr_req_i = 1'b0;
    wait_idle(1'b0, "R8");

    // VGA without phase; request glitches mid-script (R5, R10)
    phase_vld_i = 1'b0; bias_i = 8'hA6;
    push_up(1'b1, 1'b0, 4'h0, 1'b1, 8'hA6);
    pwr_req_i = 1'b1;
    repeat (30) @(negedge clk_i);
    pwr_req_i = 1'b0;
    repeat (10) @(negedge clk_i);
    pwr_req_i = 1'b1;
    wait_idle(1'b1, "R10");
    quiet(100);

    // request reversed during power-down -> up follows (R10)
    vga_mode_i = 1'b0; bias_vld_i = 1'b0;
    push_down();
    push_up(1'b0, 1'b0, 4'h0, 1'b0, 8'h00);
    last_ref = cyc;
    pwr_req_i = 1'b0;
    repeat (100) @(negedge clk_i);
    pwr_req_i = 1'b1;
    wait_idle(1'b1, "R10");
    quiet(50);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule